// File: doc/BRIEF.md
# Framebuffer Pixel Serializer with Doubling

This block turns 64-bit framebuffer words into a 4-bit colour pixel stream, one pixel per clock while display-enable is high. It fetches each scanline from a simple in-order memory read port and holds the words in a small prefetch buffer. It supports a 4-bit-per-pixel colour mode and a 1-bit-per-pixel monochrome mode. As options, it holds each pixel for two clocks (half width) and shows each framebuffer line on two scanlines (half height).

An external sync generator supplies a frame pulse, a scanline pulse, a vertical-active gate and display-enable. Software queues a frame base address at any time. The block adopts that address only at the next frame pulse. Lines start at the base plus whole multiples of a programmable byte pitch, so rows may carry padding. If data is missing while pixels are due, the block shows black and records the event in a sticky flag.

Top module: `fb_pixel_serializer`

## Requirements
- R1: With `mono`=0, pixel k of a word (k=0 is leftmost, 16 per word) is `rd_data[4k+3:4k]`, so the low nibble of each byte comes first. It appears unchanged on `pix`: bit 3 intensity, bit 2 red, bit 1 green, bit 0 blue.
- R2: With `mono`=1, pixel k of a word (64 per word, bit 0 of each byte leftmost) is `rd_data[k]`. That bit is copied onto all four `pix` bits, so `pix` is 4'h0 or 4'hF.
- R3: Whenever `de` is low, `pix` is 4'h0.
- R4: With `half_w`=1, each framebuffer pixel is shown for two consecutive display-enable clocks.
- R5: At each scanline pulse with `vact` high, the block requests exactly ceil(W×bpp/64) words. W is `width`, or `width`/2 when `half_w`=1. The words are at consecutive byte addresses that step by 8.
- R6: The first active scanline of a frame reads from the frame base. Each later framebuffer line starts `pitch` bytes after the previous one, whatever the number of bytes the line uses.
- R7: With `half_h`=1, every framebuffer line is fetched twice: the second active scanline of each pair reuses the same addresses.
- R8: A pulse on `base_wr` stores `base_in` and sets `base_pending` from the next cycle. At a `frame_evt` the pending address becomes the frame base, and `base_pending` clears unless `base_wr` is also high in that cycle. Without a pending address, the previous frame base is reused.
- R9: If `de` is high while the prefetch buffer is empty, `pix` is 4'h0 and the pixel position does not advance. `underflow` then rises on the next cycle and stays high until reset.
- R10: Buffered words, requested words and discarded in-flight responses together never exceed DEPTH (default 4). Responses still in flight when a scanline or frame pulse arrives are dropped and never shown.
- R11: No request is issued in the cycle of a frame or scanline pulse. After a frame pulse, or after a scanline pulse with `vact` low, no request is issued until the next scanline pulse with `vact` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mono | input | 1 | 1 = 1-bpp mode, 0 = 4-bpp mode |
| half_w | input | 1 | Hold each pixel for two clocks |
| half_h | input | 1 | Show each line on two scanlines |
| width | input | WW | Active width in output pixels |
| pitch | input | AW | Byte distance between framebuffer lines |
| base_in | input | AW | Frame base byte address to queue |
| base_wr | input | 1 | Queue strobe for `base_in` |
| base_pending | output | 1 | A queued base awaits the next frame pulse |
| frame_evt | input | 1 | Frame start pulse |
| line_evt | input | 1 | Scanline start pulse, ahead of display-enable |
| vact | input | 1 | Vertical-active gate, sampled with `line_evt` |
| de | input | 1 | Display enable |
| rd_req | output | 1 | Word read request, accepted in the cycle it is high |
| rd_addr | output | AW | Byte address of the requested word |
| rd_valid | input | 1 | Read response valid, in request order |
| rd_data | input | 64 | Read response word, byte 0 in bits 7:0 |
| pix | output | 4 | Pixel out: intensity, red, green, blue |
| underflow | output | 1 | Sticky: pixels were due with no data |

## Verification
The hardest case to reach is stale data: responses from a scanline whose fetch was cut short must still arrive and then be thrown away. Only then may the next line's words be shown. The bench reaches this case by withholding every memory response for one whole active line. The block spends its full prefetch allowance, shows black and raises the underflow flag. The held responses are released in the same cycle as the next scanline pulse, so they arrive just ahead of that line's own fetches. The reference model then checks that every pixel of the new line comes from the new addresses, and that the new line requests exactly its word count.

// File: rtl/fb_pixel_serializer.sv
module fb_pixel_serializer #(
  parameter int AW    = 32,
  parameter int WW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mono,
  input  logic          half_w,
  input  logic          half_h,
  input  logic [WW-1:0] width,
  input  logic [AW-1:0] pitch,
  input  logic [AW-1:0] base_in,
  input  logic          base_wr,
  output logic          base_pending,
  input  logic          frame_evt,
  input  logic          line_evt,
  input  logic          vact,
  input  logic          de,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [63:0]   rd_data,
  output logic [3:0]    pix,
  output logic          underflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] base_q, frame_base, line_addr, faddr, nxt_line;
  logic          first, rep, nxt_rep;
  logic [WW-1:0] words_left, fw, wpl;
  logic [CW-1:0] cnt, outst, drop;
  logic [PW-1:0] wp, rp;
  logic [63:0]   mem [DEPTH];
  logic [5:0]    pidx;
  logic          hph;

  wire flush    = frame_evt | line_evt;
  wire live_ret = rd_valid && (drop == '0);
  wire drop_ret = rd_valid && (drop != '0);
  wire space    = ((CW+2)'(cnt) + (CW+2)'(outst) + (CW+2)'(drop)) < (CW+2)'(DEPTH);

  assign fw  = half_w ? (width >> 1) : width;
  assign wpl = mono ? WW'((32'(fw) + 32'd63) >> 6) : WW'((32'(fw) + 32'd15) >> 4);

  assign rd_req  = !flush && (words_left != '0) && space;
  assign rd_addr = faddr;

  always_comb begin
    if (first) begin
      nxt_line = line_addr;
      nxt_rep  = 1'b0;
    end else if (half_h && !rep) begin
      nxt_line = line_addr;
      nxt_rep  = 1'b1;
    end else begin
      nxt_line = line_addr + pitch;
      nxt_rep  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q       <= '0;
      base_pending <= 1'b0;
      frame_base   <= '0;
      line_addr    <= '0;
      faddr        <= '0;
      first        <= 1'b1;
      rep          <= 1'b0;
      words_left   <= '0;
    end else begin
      if (frame_evt) begin
        if (base_pending) begin
          frame_base <= base_q;
          line_addr  <= base_q;
        end else begin
          line_addr  <= frame_base;
        end
        base_pending <= 1'b0;
        first        <= 1'b1;
        rep          <= 1'b0;
        words_left   <= '0;
      end else if (line_evt) begin
        if (vact) begin
          line_addr  <= nxt_line;
          rep        <= nxt_rep;
          first      <= 1'b0;
          faddr      <= nxt_line;
          words_left <= wpl;
        end else begin
          words_left <= '0;
        end
      end else if (rd_req) begin
        faddr      <= faddr + AW'(8);
        words_left <= words_left - WW'(1);
      end
      if (base_wr) begin
        base_q       <= base_in;
        base_pending <= 1'b1;
      end
    end
  end

  wire        have = (cnt != '0);
  wire [63:0] head = mem[rp];
  wire [5:0]  last = mono ? 6'd63 : 6'd15;
  wire        show = de && have;
  wire        step = show && (!half_w || hph);
  wire        pop  = step && (pidx == last);
  wire [3:0]  nib  = head[{pidx[3:0], 2'b00} +: 4];

  assign pix = show ? (mono ? {4{head[pidx]}} : nib) : 4'h0;

  always_ff @(posedge clk) begin
    if (live_ret && !flush) mem[wp] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      outst <= '0;
      drop  <= '0;
      pidx  <= '0;
      hph   <= 1'b0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      outst <= '0;
      drop  <= drop - CW'(drop_ret) + outst - CW'(live_ret);
      pidx  <= '0;
      hph   <= 1'b0;
    end else begin
      if (live_ret) wp <= wp + PW'(1);
      if (pop)      rp <= rp + PW'(1);
      cnt   <= cnt + CW'(live_ret) - CW'(pop);
      outst <= outst + CW'(rd_req) - CW'(live_ret);
      drop  <= drop - CW'(drop_ret);
      if (show) begin
        if (half_w && !hph) begin
          hph <= 1'b1;
        end else begin
          hph  <= 1'b0;
          pidx <= pop ? 6'd0 : pidx + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           underflow <= 1'b0;
    else if (de && !have) underflow <= 1'b1;
  end
endmodule

// File: rtl/fb_pixel_serializer_chk.sv
module fb_pixel_serializer_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mono,
  input logic          de,
  input logic          vact,
  input logic [3:0]    pix,
  input logic          frame_evt,
  input logic          line_evt,
  input logic          base_wr,
  input logic          base_pending,
  input logic          underflow,
  input logic          rd_req,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] outst,
  input logic [CW-1:0] drop
);
  a_r3_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> pix == 4'h0);

  a_r2_mono_levels: assert property (@(posedge clk) disable iff (!rst_n)
    mono |-> (pix == 4'h0 || pix == 4'hF));

  a_r8_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> base_pending);

  a_r8_pending_taken: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt && !base_wr |=> !base_pending);

  a_r9_underflow_raise: assert property (@(posedge clk) disable iff (!rst_n)
    de && cnt == '0 |=> underflow);

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((CW+2)'(cnt) + (CW+2)'(outst) + (CW+2)'(drop)) <= (CW+2)'(DEPTH));

  a_r11_quiet_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt || line_evt |-> !rd_req);

  a_r11_idle_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt && !vact && !frame_evt |=> !rd_req);
endmodule

bind fb_pixel_serializer fb_pixel_serializer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mono(mono), .de(de), .vact(vact), .pix(pix),
  .frame_evt(frame_evt), .line_evt(line_evt), .base_wr(base_wr),
  .base_pending(base_pending), .underflow(underflow), .rd_req(rd_req),
  .cnt(cnt), .outst(outst), .drop(drop)
);

// File: tb/tb_fb_pixel_serializer.sv
module tb_fb_pixel_serializer;
  localparam int AW = 32, WW = 12, DEPTH = 4, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic mono = 0, half_w = 0, half_h = 0;
  logic [WW-1:0] width = 0;
  logic [AW-1:0] pitch = 0, base_in = 0;
  logic base_wr = 0, frame_evt = 0, line_evt = 0, vact = 0, de = 0;
  logic base_pending, rd_req, underflow, rd_valid = 0;
  logic [AW-1:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic [3:0] pix;

  fb_pixel_serializer #(.AW(AW), .WW(WW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mono(mono), .half_w(half_w), .half_h(half_h),
    .width(width), .pitch(pitch), .base_in(base_in), .base_wr(base_wr),
    .base_pending(base_pending), .frame_evt(frame_evt), .line_evt(line_evt),
    .vact(vact), .de(de), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .pix(pix), .underflow(underflow));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [63:0] memw(input logic [31:0] a);
    return {a ^ 32'h5A3C_96E1, (a * 32'h9E37_79B9) ^ 32'h0F1E_2D3C};
  endfunction

  // reference model state
  logic [31:0] m_fbase = 0, m_pval = 0, m_line = 0, m_faddr = 0;
  bit m_pend = 0, m_first = 1, m_rep = 0, m_hold = 0, cur_hold = 0;
  bit mon_on = 0, uf_expect = 0, cur_active = 0;
  int m_words = 0, m_x = 0, line_reqs = 0, cur_wpl = 0, cyc = 0;
  logic [31:0] q_addr[$];
  int q_due[$];

  function automatic int model_wpl();
    int fw;
    fw = half_w ? int'(width) / 2 : int'(width);
    return mono ? (fw + 63) / 64 : (fw + 15) / 16;
  endfunction

  task automatic end_line_check();
    if (cur_active) begin
      if (cur_hold) chk("R10 requests while starved", line_reqs, DEPTH);
      else          chk("R5 words per line", line_reqs, cur_wpl);
    end
  endtask

  task automatic step();
    int fx, ppw, k;
    logic [63:0] d;
    logic [3:0] e;
    chk("R8 base_pending", base_pending, m_pend);
    if (!de) chk("R3 blank", pix, 4'h0);
    else if (m_hold) chk("R9 black when empty", pix, 4'h0);
    else begin
      fx  = half_w ? m_x / 2 : m_x;
      ppw = mono ? 64 : 16;
      d   = memw(m_line + 32'(8 * (fx / ppw)));
      k   = fx % ppw;
      e   = mono ? {4{d[k]}} : d[4*k +: 4];
      chk(mono ? "R2 mono pixel" : (half_w ? "R4 half-width pixel" : "R1 colour pixel"), pix, e);
      m_x++;
    end
    if (!m_hold) chk("R9 underflow flag", underflow, uf_expect);
    if (rd_req) begin
      line_reqs++;
      if (m_words == 0) chk("R11 unexpected request", 1, 0);
      else begin
        chk(half_h ? "R7 line address" : "R6 line address", rd_addr, m_faddr);
        m_faddr += 8;
        m_words--;
      end
      q_addr.push_back(rd_addr);
      q_due.push_back(cyc + LAT);
    end
    if (q_addr.size() > 0 && q_due[0] <= cyc && !m_hold) begin
      rd_valid = 1;
      rd_data  = memw(q_addr.pop_front());
      void'(q_due.pop_front());
    end else begin
      rd_valid = 0;
      rd_data  = 0;
    end
    if (frame_evt) begin
      end_line_check();
      cur_active = 0;
      if (m_pend) m_fbase = m_pval;
      m_pend = 0; m_line = m_fbase; m_first = 1; m_rep = 0; m_words = 0;
    end else if (line_evt) begin
      end_line_check();
      if (vact) begin
        if (m_first) begin m_first = 0; m_rep = 0; end
        else if (half_h && !m_rep) m_rep = 1;
        else begin m_rep = 0; m_line += pitch; end
        m_faddr = m_line; m_words = model_wpl();
      end else m_words = 0;
      cur_active = vact; cur_wpl = model_wpl(); cur_hold = m_hold;
      m_x = 0; line_reqs = 0;
    end
    if (base_wr) begin m_pval = base_in; m_pend = 1; end
    cyc++;
  endtask

  initial forever begin
    @(negedge clk);
    #2;
    if (mon_on) step();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (R1..all) actual=timeout expected=finished");
    finish_run();
  end

  task automatic qbase(input logic [31:0] a);
    @(negedge clk); base_wr = 1; base_in = a;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic fpulse();
    @(negedge clk); frame_evt = 1;
    @(negedge clk); frame_evt = 0;
  endtask

  task automatic line(input bit v, input int dl, input bit hold);
    @(negedge clk); line_evt = 1; vact = v; m_hold = hold;
    @(negedge clk); line_evt = 0;
    repeat (20) @(negedge clk);
    if (v) begin
      de = 1;
      repeat (dl) @(negedge clk);
      de = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input bit mo, input bit hw, input bit hh, input int w, input int p);
    @(negedge clk);
    mono = mo; half_w = hw; half_h = hh; width = WW'(w); pitch = AW'(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R11 reset rd_req", rd_req, 0);
    chk("R3 reset pix", pix, 0);
    chk("R8 reset base_pending", base_pending, 0);
    chk("R9 reset underflow", underflow, 0);
    mon_on = 1;

    // colour mode, plain
    cfg(0, 0, 0, 40, 'h40);
    qbase(32'h1000);
    fpulse();
    line(0, 0, 0); line(0, 0, 0);
    for (int i = 0; i < 4; i++) line(1, 40, 0);
    line(0, 0, 0);

    // mono mode, base queued mid-frame
    cfg(1, 0, 0, 100, 'h20);
    fpulse();
    line(0, 0, 0);
    line(1, 100, 0);
    qbase(32'h2000);
    line(1, 100, 0);
    line(1, 100, 0);
    fpulse();
    line(1, 100, 0); line(1, 100, 0);

    // half width and half height, colour
    cfg(0, 1, 1, 40, 'h30);
    fpulse();
    line(0, 0, 0);
    for (int i = 0; i < 5; i++) line(1, 40, 0);

    // half width mono, base reused across frames
    cfg(1, 1, 0, 128, 'h18);
    fpulse();
    line(1, 128, 0); line(1, 128, 0);

    // starved line, then stale responses dropped
    cfg(0, 0, 0, 100, 'h80);
    qbase(32'h4000);
    fpulse();
    line(1, 100, 1);
    uf_expect = 1;
    line(1, 100, 0);
    line(1, 100, 0);
    fpulse();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule